// File: doc/BRIEF.md
# Radix-2 DIF Butterfly with Block Exponent

This block is the arithmetic core of a decimation-in-frequency FFT engine. Each clock it accepts one pair of complex operands, x0 and x1, with one complex twiddle. Three cycles later it returns the sum x0 + x1 and the twiddled difference W·(x0 − x1). Data are fixed-point fractions with one integer (sign) bit.

The twiddle arrives negated. The stored pattern is the two's-complement code of −W. This lets the most common twiddle, +1.0, be held exactly as the most negative code. The block negates it back as part of the complex multiply.

All results of one pass share a block exponent. A pass is opened by `pass_start`, and the first pass of a transform also raises `xform_start`. When any result of a pass has to be clipped to the data range, every operand of the following pass is halved by an arithmetic right shift, and the exponent grows by one. The true value of every output is the output code times 2^exponent. A controller outside the block sequences the addresses, the passes and the twiddle reads.

Top module: `dif_butterfly`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, all four result outputs are 0 and `exponent` equals `EXP_INIT`.
- R2: A butterfly presented with `in_valid` high appears with `out_valid` high exactly 3 clock edges later. One butterfly is accepted every clock, and each accepted butterfly produces exactly one output.
- R3: `y0` = s0 + s1 per component, where s0 and s1 are the operands after the pass shift.
- R4: The twiddle value is W = −(t_re + j·t_im)/2^(TW−1), where t is the stored code. `y1` = W·(s0 − s1). The code −2^(TW−1) in the real field therefore gives W = +1 exactly, and the same code in the imaginary field gives W = +j.
- R5: Each `y1` component is the raw product divided by 2^(TW−1), rounded half up: add 2^(TW−2), then shift right arithmetically by TW−1.
- R6: A result outside [−2^(DW−1), 2^(DW−1)−1] is clipped to the nearer bound and marks the pass as overflowed.
- R7: If a pass overflowed, the next `pass_start` (without `xform_start`) sets halving for the whole new pass: each operand component is shifted right arithmetically by one bit. The exponent rises by one at that edge.
- R8: If a pass did not overflow, the next `pass_start` leaves the operands unshifted and the exponent unchanged.
- R9: `pass_start` together with `xform_start` loads `EXP_INIT`, clears halving and discards any overflow of the previous pass.
- R10: When `out_valid` is 0 the result outputs hold their last values. Inputs presented with `in_valid` low neither change the outputs nor mark an overflow.
- R11: `pass_start` is legal only when the first two pipeline stages are empty. The exponent changes only at a `pass_start` edge. The new pass applies to the butterfly presented in the same cycle as `pass_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and twiddle are valid this cycle |
| pass_start | input | 1 | First cycle of a new pass |
| xform_start | input | 1 | With `pass_start`: first pass of a new transform |
| x0_re | input | DW | Operand x0, real part |
| x0_im | input | DW | Operand x0, imaginary part |
| x1_re | input | DW | Operand x1, real part |
| x1_im | input | DW | Operand x1, imaginary part |
| tw_re | input | TW | Negated twiddle code, real part |
| tw_im | input | TW | Negated twiddle code, imaginary part |
| out_valid | output | 1 | Results valid |
| y0_re | output | DW | Sum, real part |
| y0_im | output | DW | Sum, imaginary part |
| y1_re | output | DW | Twiddled difference, real part |
| y1_im | output | DW | Twiddled difference, imaginary part |
| exponent | output | EW | Block exponent of the current pass |

## Verification
On every cycle the assertions check several properties. They check the three-cycle valid latency and that results hold while no output is valid. They check that an overflow is recorded only together with a valid result, that `pass_start` arrives into a drained pipeline, and that the exponent moves only at pass edges, by at most one step, or back to its initial value. The arithmetic itself can only be shown by the bench scenarios, which compare every output against a model computed from the requirements: the sums, the negated-twiddle product with its rounding, the clipping, and the halving of a following pass. The bench sweeps every pair of one operand field and every twiddle code on a small configuration, and it drives hand-worked cases for +1, +j, ±0.5 and saturation.

// File: rtl/dif_butterfly.sv
module dif_butterfly #(
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter int EW       = 4,
  parameter int EXP_INIT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 pass_start,
  input  logic                 xform_start,
  input  logic signed [DW-1:0] x0_re,
  input  logic signed [DW-1:0] x0_im,
  input  logic signed [DW-1:0] x1_re,
  input  logic signed [DW-1:0] x1_im,
  input  logic signed [TW-1:0] tw_re,
  input  logic signed [TW-1:0] tw_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] y0_re,
  output logic signed [DW-1:0] y0_im,
  output logic signed [DW-1:0] y1_re,
  output logic signed [DW-1:0] y1_im,
  output logic [EW-1:0]        exponent
);

  localparam int SW = DW + 1;
  localparam int PW = SW + TW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = PW'(-(2 ** (DW - 1)));
  localparam logic signed [PW-1:0] RND  = PW'(2 ** (TW - 2));

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  function automatic logic outside(input logic signed [PW-1:0] v);
    return (v > MAXV) || (v < MINV);
  endfunction

  logic scale, ovf_acc, next_scale, s_eff;
  assign next_scale = xform_start ? 1'b0 : ovf_acc;
  assign s_eff      = pass_start ? next_scale : scale;

  logic signed [DW-1:0] a0r, a0i, a1r, a1i;
  assign a0r = s_eff ? (x0_re >>> 1) : x0_re;
  assign a0i = s_eff ? (x0_im >>> 1) : x0_im;
  assign a1r = s_eff ? (x1_re >>> 1) : x1_re;
  assign a1i = s_eff ? (x1_im >>> 1) : x1_im;

  logic                 v1, v2;
  logic signed [SW-1:0] sum_re1, sum_im1, dif_re1, dif_im1, sum_re2, sum_im2;
  logic signed [TW-1:0] twr1, twi1;
  logic signed [PW-1:0] pr2, pi2;

  logic signed [PW-1:0] p_re, p_im, r_re, r_im, e_re, e_im;
  assign p_re = PW'(dif_im1) * PW'(twi1) - PW'(dif_re1) * PW'(twr1);
  assign p_im = -(PW'(dif_re1) * PW'(twi1) + PW'(dif_im1) * PW'(twr1));
  assign r_re = (pr2 + RND) >>> (TW - 1);
  assign r_im = (pi2 + RND) >>> (TW - 1);
  assign e_re = PW'(sum_re2);
  assign e_im = PW'(sum_im2);

  logic ovf_any;
  assign ovf_any = outside(e_re) | outside(e_im) | outside(r_re) | outside(r_im);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      sum_re1 <= '0; sum_im1 <= '0; dif_re1 <= '0; dif_im1 <= '0;
      twr1 <= '0; twi1 <= '0;
      sum_re2 <= '0; sum_im2 <= '0; pr2 <= '0; pi2 <= '0;
      y0_re <= '0; y0_im <= '0; y1_re <= '0; y1_im <= '0;
      scale <= 1'b0; ovf_acc <= 1'b0;
      exponent <= EW'(EXP_INIT);
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        sum_re1 <= SW'(a0r) + SW'(a1r);
        sum_im1 <= SW'(a0i) + SW'(a1i);
        dif_re1 <= SW'(a0r) - SW'(a1r);
        dif_im1 <= SW'(a0i) - SW'(a1i);
        twr1    <= tw_re;
        twi1    <= tw_im;
      end
      v2 <= v1;
      if (v1) begin
        sum_re2 <= sum_re1;
        sum_im2 <= sum_im1;
        pr2     <= p_re;
        pi2     <= p_im;
      end
      out_valid <= v2;
      if (v2) begin
        y0_re <= clip(e_re);
        y0_im <= clip(e_im);
        y1_re <= clip(r_re);
        y1_im <= clip(r_im);
      end
      if (pass_start) begin
        scale    <= next_scale;
        exponent <= xform_start ? EW'(EXP_INIT) : exponent + EW'(next_scale);
        ovf_acc  <= 1'b0;
      end else if (v2 && ovf_any) begin
        ovf_acc  <= 1'b1;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  assert_drained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |-> (!v1 && !v2));

  assert_exp_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_start |=> $stable(exponent));

  assert_exp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !xform_start) |=> (EW'(exponent - $past(exponent)) <= EW'(1)));

  assert_exp_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && xform_start) |=> (exponent == EW'(EXP_INIT)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(y0_re) && $stable(y0_im) && $stable(y1_re) && $stable(y1_im)));

  assert_ovf_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_acc) |-> out_valid);

endmodule

// File: tb/sim_dif_butterfly.sv
module sim_dif_butterfly;
  localparam int DW = 6;
  localparam int TW = 6;
  localparam int EW = 4;
  localparam int EI = 2;
  localparam int MX = (1 << (DW - 1)) - 1;
  localparam int MN = -(1 << (DW - 1));

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, pass_start, xform_start, out_valid;
  logic signed [DW-1:0] x0_re, x0_im, x1_re, x1_im, y0_re, y0_im, y1_re, y1_im;
  logic signed [TW-1:0] tw_re, tw_im;
  logic [EW-1:0] exponent;

  dif_butterfly #(.DW(DW), .TW(TW), .EW(EW), .EXP_INIT(EI)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pass_start(pass_start),
    .xform_start(xform_start), .x0_re(x0_re), .x0_im(x0_im), .x1_re(x1_re),
    .x1_im(x1_im), .tw_re(tw_re), .tw_im(tw_im), .out_valid(out_valid),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im), .exponent(exponent));

  int checks = 0, errors = 0;
  int q0r[$], q0i[$], q1r[$], q1i[$];
  int m_scale = 0, m_exp = EI, m_ovf = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clipi(int v);
    return (v > MX) ? MX : ((v < MN) ? MN : v);
  endfunction

  function automatic int ovi(int v);
    return ((v > MX) || (v < MN)) ? 1 : 0;
  endfunction

  function automatic int expv();
    return m_exp & ((1 << EW) - 1);
  endfunction

  task automatic drive(int a0r, int a0i, int a1r, int a1i, int tr, int ti, bit ps, bit xs);
    int s0r, s0i, s1r, s1i, sr, si, dr, di, pr, pim, rr, ri;
    if (ps) begin
      int ns;
      ns = xs ? 0 : m_ovf;
      m_exp = xs ? EI : m_exp + ns;
      m_scale = ns;
      m_ovf = 0;
    end
    s0r = m_scale ? (a0r >>> 1) : a0r;
    s0i = m_scale ? (a0i >>> 1) : a0i;
    s1r = m_scale ? (a1r >>> 1) : a1r;
    s1i = m_scale ? (a1i >>> 1) : a1i;
    sr = s0r + s1r; si = s0i + s1i;
    dr = s0r - s1r; di = s0i - s1i;
    pr  = di * ti - dr * tr;
    pim = -(dr * ti + di * tr);
    rr = (pr  + (1 << (TW - 2))) >>> (TW - 1);
    ri = (pim + (1 << (TW - 2))) >>> (TW - 1);
    q0r.push_back(clipi(sr)); q0i.push_back(clipi(si));
    q1r.push_back(clipi(rr)); q1i.push_back(clipi(ri));
    if (ovi(sr) | ovi(si) | ovi(rr) | ovi(ri)) m_ovf = 1;
    in_valid = 1'b1; pass_start = ps; xform_start = xs;
    x0_re = DW'(a0r); x0_im = DW'(a0i); x1_re = DW'(a1r); x1_im = DW'(a1i);
    tw_re = TW'(tr); tw_im = TW'(ti);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0; pass_start = 1'b0; xform_start = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic single(int a0r, int a0i, int a1r, int a1i, int tr, int ti, bit ps, bit xs,
                        string req, int e0r, int e0i, int e1r, int e1i);
    drive(a0r, a0i, a1r, a1i, tr, ti, ps, xs);
    idle(2);
    chk("R2", "out_valid at third edge", int'(out_valid), 1);
    chk(req, "y0_re", int'(y0_re), e0r);
    chk(req, "y0_im", int'(y0_im), e0i);
    chk(req, "y1_re", int'(y1_re), e1r);
    chk(req, "y1_im", int'(y1_im), e1i);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q0r.size() == 0) begin
        chk("R2", "unexpected output", 1, 0);
      end else begin
        chk("R3", "y0_re model", int'(y0_re), q0r.pop_front());
        chk("R3", "y0_im model", int'(y0_im), q0i.pop_front());
        chk("R4", "y1_re model", int'(y1_re), q1r.pop_front());
        chk("R4", "y1_im model", int'(y1_im), q1i.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h0r, h0i, h1r, h1i;
    rst_n = 1'b0; in_valid = 1'b0; pass_start = 1'b0; xform_start = 1'b0;
    x0_re = '0; x0_im = '0; x1_re = '0; x1_im = '0; tw_re = '0; tw_im = '0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "exponent in reset", int'(exponent), EI);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "y0_re", int'(y0_re), 0);
    chk("R1", "y1_im", int'(y1_im), 0);
    chk("R1", "exponent", int'(exponent), EI);

    // Directed pass: W=+1, latency, rounding, +j, saturation
    drive(5, -3, -4, 6, -32, 0, 1'b1, 1'b1);
    chk("R9", "exponent after transform start", int'(exponent), EI);
    chk("R2", "out_valid after 1 edge", int'(out_valid), 0);
    idle(1);
    chk("R2", "out_valid after 2 edges", int'(out_valid), 0);
    idle(1);
    chk("R2", "out_valid after 3 edges", int'(out_valid), 1);
    chk("R3", "y0_re", int'(y0_re), 1);
    chk("R3", "y0_im", int'(y0_im), 3);
    chk("R4", "y1_re W=+1", int'(y1_re), 9);
    chk("R4", "y1_im W=+1", int'(y1_im), -9);
    single(1, 0, 0, 0, -16, 0, 1'b0, 1'b0, "R5", 1, 0, 1, 0);
    single(1, 0, 0, 0, 16, 0, 1'b0, 1'b0, "R5", 1, 0, 0, 0);
    single(1, 0, 0, 0, 0, -32, 1'b0, 1'b0, "R4", 1, 0, 0, 1);
    single(31, -32, 31, -32, -32, 0, 1'b0, 1'b0, "R6", 31, -32, 0, 0);
    idle(3);

    // Pass 1: new transform despite prior overflow; full sweep of real fields
    for (int i = 0; i < 4096; i++) begin
      drive((i >> 6) - 32, ((i * 7) & 63) - 32, (i & 63) - 32, ((i * 13) & 63) - 32,
            ((i * 29) & 63) - 32, ((i * 11 + 5) & 63) - 32, i == 0, i == 0);
      if (i == 0) chk("R9", "exponent reloads", int'(exponent), EI);
    end
    idle(3);
    chk("R11", "exponent stable through pass", int'(exponent), EI);

    // Pass 2: halved operands, full twiddle sweep
    for (int i = 0; i < 4096; i++) begin
      drive((i % 15) - 7, ((i / 15) % 15) - 7, ((i * 3) % 15) - 7, ((i * 7) % 13) - 6,
            (i >> 6) - 32, (i & 63) - 32, i == 0, 1'b0);
      if (i == 0) begin
        chk("R7", "exponent after overflowed pass", int'(exponent), EI + 1);
        chk("R7", "exponent model", int'(exponent), expv());
      end
    end
    idle(3);
    chk("R8", "pass 2 model saw no overflow", m_ovf, 0);

    // Invalid cycles with extreme data must not disturb anything
    h0r = int'(y0_re); h0i = int'(y0_im); h1r = int'(y1_re); h1i = int'(y1_im);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b0; pass_start = 1'b0; xform_start = 1'b0;
      x0_re = DW'(MX); x0_im = DW'(MN); x1_re = DW'(MX); x1_im = DW'(MN);
      tw_re = TW'(MN); tw_im = TW'(MN);
      @(negedge clk);
      chk("R10", "out_valid low", int'(out_valid), 0);
      chk("R10", "y0_re held", int'(y0_re), h0r);
      chk("R10", "y0_im held", int'(y0_im), h0i);
      chk("R10", "y1_re held", int'(y1_re), h1r);
      chk("R10", "y1_im held", int'(y1_im), h1i);
    end

    // Pass 3: no prior overflow, full sweep of imaginary fields
    for (int i = 0; i < 4096; i++) begin
      drive(((i * 5) & 63) - 32, (i >> 6) - 32, ((i * 9 + 3) & 63) - 32, (i & 63) - 32,
            ((i * 23) & 63) - 32, ((i * 17 + 1) & 63) - 32, i == 0, 1'b0);
      if (i == 0) chk("R8", "exponent unchanged after clean pass", int'(exponent), EI + 1);
    end
    idle(3);

    // Pass 4: halved again
    for (int i = 0; i < 64; i++) begin
      drive((i & 63) - 32, 31 - (i & 63), ((i * 3) & 63) - 32, ((i * 5) & 63) - 32,
            ((i * 7) & 63) - 32, -32, i == 0, 1'b0);
      if (i == 0) chk("R7", "exponent second step", int'(exponent), EI + 2);
    end
    idle(3);

    // Pass 5: new transform
    for (int i = 0; i < 64; i++) begin
      drive((i & 63) - 32, (i & 7), 31 - (i & 63), -(i & 7), -32, (i & 63) - 32, i == 0, i == 0);
      if (i == 0) chk("R9", "exponent back to initial", int'(exponent), EI);
    end
    idle(5);
    chk("R2", "pending results", q0r.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule